// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor whose low address byte and data byte share one set of pins. A single request names the kind of cycle, a 16-bit address and a write byte. The block then walks through a fixed run of clock-period T-states. In the first T-state it puts the address out and pulses the address latch strobe. In the following T-states it either releases the shared bus and pulls the read strobe low, or drives the write byte and pulls the write strobe low. Read data is captured when the third T-state ends, and a one-clock done pulse marks the end of the cycle.

The processor core issues one request whenever the sequencer is at rest. That includes the clock in which done is high, so cycles can follow each other with no gap. Any request made while a cycle is in progress is ignored. The shared bus is split into an output byte, an output enable and an input byte, so that a pad ring can build the tri-state pin.

Top module: `mbus_seq`

## Requirements
- R1: Cycle kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 bus idle. The cycle lengths are: opcode fetch 4 T-states; memory and I/O reads and writes 3 T-states; bus idle 2 T-states, or 3 when `req_idle_long` is 1. `done` stays low during every T-state.
- R2: In T1 of every kind except bus idle, `ale`=1, `ad_oe`=1 and `ad_o` carries the low address byte. Through all T-states of a cycle, `a_hi` carries the high address byte captured at the request.
- R3: Throughout a cycle, {`st1`,`st0`} is 11 for opcode fetch, 10 for memory or I/O read, 01 for memory or I/O write and 00 for bus idle. `io_sel` is 1 for I/O kinds and 0 for all others.
- R4: An I/O cycle uses `req_addr[7:0]` as its port number and puts it on both `a_hi` and the low address byte.
- R5: After T1, `ale` is 0. In T2 and T3 of a fetch or read, `rd_n`=0, `wr_n`=1 and `ad_oe`=0. In T4 of a fetch, `rd_n`=1 and `ad_oe`=0.
- R6: In T2 and T3 of a memory or I/O write, `wr_n`=0, `rd_n`=1, `ad_oe`=1 and `ad_o` equals the write byte.
- R7: For fetch and read kinds, `rdata` takes the `ad_i` value present in T3 on the clock edge that ends T3, and later changes on `ad_i` do not alter it. Write and idle cycles leave `rdata` unchanged.
- R8: `done` is high for exactly the one clock after the last T-state. A request made in that clock starts the next cycle's T1 on the following clock.
- R9: A request made while a cycle is in progress has no effect. A request with kind code 6 or 7 starts no cycle.
- R10: After reset, and between cycles, `rd_n`=`wr_n`=1, `ale`=0, `ad_oe`=0, `a_hi`=0, {`st1`,`st0`}=00 and `done`=0. Reset clears `rdata` to 0.
- R11: A bus idle cycle raises no strobe: `ale`=0, `rd_n`=`wr_n`=1 and `ad_oe`=0 in all of its T-states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request a bus cycle (taken only when at rest) |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_idle_long | input | 1 | Bus idle lasts 3 T-states instead of 2 |
| ad_i | input | 8 | Shared bus input byte |
| a_hi | output | 8 | High address byte |
| ad_o | output | 8 | Shared bus output byte |
| ad_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | 1 for I/O cycles, 0 for memory |
| st1 | output | 1 | Status bit 1 |
| st0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
A request is registered on the edge that accepts it, so T1 is visible from the next clock. Each later T-state appears one clock after the one before it. Done and the captured byte become visible in the clock after the last T-state.

The bench drives stimulus at falling edges and samples at the falling edge inside each T-state, where it checks that T-state's pins. It changes `ad_i` in T4 of a fetch so that a late capture would show up as a wrong byte. It also keeps a stray request asserted through a whole cycle to show that the request is not taken mid-cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_IDLE  = 3'd5
    } kind_e;

    function automatic logic kind_ok(input logic [2:0] k);
        return k <= 3'd5;
    endfunction

    function automatic logic kind_io(input logic [2:0] k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_rd(input logic [2:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_wr(input logic [2:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    // number of T-states of a cycle kind
    function automatic logic [2:0] kind_len(input logic [2:0] k, input logic idle_long);
        if (k == K_FETCH) return 3'd4;
        if (k == K_IDLE)  return idle_long ? 3'd3 : 3'd2;
        return 3'd3;
    endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [2*DW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            req_idle_long,
    input  logic [DW-1:0]   ad_i,
    output logic [2:0]      tcnt,
    output logic [2:0]      kind,
    output logic [2*DW-1:0] addr,
    output logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            done
);

    localparam int AW = 2 * DW;

    typedef struct packed {
        logic [2:0]    tcnt;   // 0 = rest, 1..4 = T1..T4
        logic [2:0]    last;
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.tcnt == 3'd0) begin
            if (req_valid && kind_ok(req_kind)) begin
                st_d.tcnt  = 3'd1;
                st_d.kind  = req_kind;
                st_d.last  = kind_len(req_kind, req_idle_long);
                st_d.addr  = kind_io(req_kind) ? {req_addr[DW-1:0], req_addr[DW-1:0]} : req_addr;
                st_d.wdata = req_wdata;
            end
        end else begin
            if (st_q.tcnt == 3'd3 && kind_rd(st_q.kind))
                st_d.rdata = ad_i;
            if (st_q.tcnt == st_q.last) begin
                st_d.tcnt = 3'd0;
                st_d.done = 1'b1;
            end else begin
                st_d.tcnt = st_q.tcnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tcnt  = st_q.tcnt;
    assign kind  = st_q.kind;
    assign addr  = st_q.addr;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;
    assign done  = st_q.done;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    fetch_only_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt == 3'd4) |-> (kind == K_FETCH));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt != 3'd0 && tcnt != st_q.last) |=> (tcnt == $past(tcnt) + 3'd1));

    // R7
    wr_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt != 3'd0 && !kind_rd(kind)) |=> $stable(rdata));

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      tcnt,
    input  logic [2:0]      kind,
    input  logic [2*DW-1:0] addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   a_hi,
    output logic [DW-1:0]   ad_o,
    output logic            ad_oe,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic            io_sel,
    output logic            st1,
    output logic            st0
);

    localparam int AW = 2 * DW;

    always_comb begin
        a_hi   = '0;
        ad_o   = '0;
        ad_oe  = 1'b0;
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        io_sel = 1'b0;
        st1    = 1'b0;
        st0    = 1'b0;
        if (tcnt != 3'd0) begin
            a_hi   = addr[AW-1:DW];
            io_sel = kind_io(kind);
            st1    = kind_rd(kind);
            st0    = kind_wr(kind) || (kind == K_FETCH);
            case (tcnt)
                3'd1: begin
                    if (kind != K_IDLE) begin
                        ale   = 1'b1;
                        ad_oe = 1'b1;
                        ad_o  = addr[DW-1:0];
                    end
                end
                3'd2, 3'd3: begin
                    if (kind_rd(kind)) begin
                        rd_n = 1'b0;
                    end else if (kind_wr(kind)) begin
                        wr_n  = 1'b0;
                        ad_oe = 1'b1;
                        ad_o  = wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5
    rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [2*DW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            req_idle_long,
    input  logic [DW-1:0]   ad_i,
    output logic [DW-1:0]   a_hi,
    output logic [DW-1:0]   ad_o,
    output logic            ad_oe,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic            io_sel,
    output logic            st1,
    output logic            st0,
    output logic [DW-1:0]   rdata,
    output logic            done
);

    logic [2:0]      tcnt;
    logic [2:0]      kind;
    logic [2*DW-1:0] addr;
    logic [DW-1:0]   wdata;

    mbus_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_idle_long(req_idle_long), .ad_i(ad_i),
        .tcnt(tcnt), .kind(kind), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done)
    );

    mbus_pins #(.DW(DW)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .tcnt(tcnt), .kind(kind), .addr(addr), .wdata(wdata),
        .a_hi(a_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel), .st1(st1), .st0(st0)
    );

endmodule

// File: tb/sim_mbus_seq.sv
module sim_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_idle_long;
    logic [7:0]  ad_i;
    logic [7:0]  a_hi, ad_o, rdata;
    logic        ad_oe, ale, rd_n, wr_n, io_sel, st1, st0, done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_rd = 8'h00;

    always #4 clk = ~clk;

    mbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_idle_long(req_idle_long),
        .ad_i(ad_i), .a_hi(a_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel), .st1(st1), .st0(st0),
        .rdata(rdata), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rest_chk(input string req);
        chk(req, "rd_n at rest", rd_n, 1);
        chk(req, "wr_n at rest", wr_n, 1);
        chk(req, "ale at rest", ale, 0);
        chk(req, "ad_oe at rest", ad_oe, 0);
        chk(req, "a_hi at rest", a_hi, 0);
        chk(req, "status at rest", {st1, st0}, 0);
    endtask

    // one complete cycle; stimulus and sampling on falling edges
    task automatic run_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                             input bit lng, input logic [7:0] rb,
                             input bit noise, input bit chained);
        bit io, rdk, wrk;
        int len, st;
        logic [15:0] ea;
        io  = (k == 3) || (k == 4);
        rdk = (k == 0) || (k == 1) || (k == 3);
        wrk = (k == 2) || (k == 4);
        len = (k == 0) ? 4 : (k == 5) ? (lng ? 3 : 2) : 3;
        st  = (k == 0) ? 3 : rdk ? 2 : wrk ? 1 : 0;
        ea  = io ? {a[7:0], a[7:0]} : a;
        if (!chained) @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_addr = a;
        req_wdata = wd; req_idle_long = lng;
        ad_i = ~rb;
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            if (t == 1) begin
                if (noise) begin   // R9: stray request held through the cycle
                    req_kind = 3'd2; req_addr = ~a; req_wdata = ~wd; req_idle_long = ~lng;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (t == 2) ad_i = rb;
            if (t == 4) ad_i = ~rb;   // R7: a late capture would see this
            chk("R1", "done within cycle", done, 0);
            chk("R3", "status bits", {st1, st0}, st);
            chk("R3", "io_sel", io_sel, io);
            chk(io ? "R4" : "R2", "a_hi", a_hi, ea[15:8]);
            if (k == 5) begin
                chk("R11", "idle ale", ale, 0);
                chk("R11", "idle rd_n", rd_n, 1);
                chk("R11", "idle wr_n", wr_n, 1);
                chk("R11", "idle ad_oe", ad_oe, 0);
            end else if (t == 1) begin
                chk("R2", "T1 ale", ale, 1);
                chk("R2", "T1 ad_oe", ad_oe, 1);
                chk(io ? "R4" : "R2", "T1 low address", ad_o, ea[7:0]);
            end else begin
                chk("R5", "ale after T1", ale, 0);
                if (t == 4) begin
                    chk("R5", "T4 rd_n", rd_n, 1);
                    chk("R5", "T4 ad_oe", ad_oe, 0);
                end else if (rdk) begin
                    chk("R5", "read rd_n", rd_n, 0);
                    chk("R5", "read wr_n", wr_n, 1);
                    chk("R5", "read ad_oe", ad_oe, 0);
                end else begin
                    chk("R6", "write wr_n", wr_n, 0);
                    chk("R6", "write rd_n", rd_n, 1);
                    chk("R6", "write ad_oe", ad_oe, 1);
                    chk("R6", "write data", ad_o, wd);
                end
            end
        end
        if (rdk) exp_rd = rb;
        @(negedge clk);
        chk("R8", "done after last T-state", done, 1);
        chk("R7", "rdata", rdata, exp_rd);
        rest_chk("R10");
        req_valid = 1'b0;
        ad_i = 8'h00;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0;
        req_wdata = 8'h0; req_idle_long = 1'b0; ad_i = 8'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rest_chk("R10");
        chk("R10", "done after reset", done, 0);
        chk("R10", "rdata after reset", rdata, 0);

        // sweep kinds, addresses and idle length
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < 4; i++)
                for (int l = 0; l < 2; l++)
                    run_cycle(k, 16'(16'h1357 * (i + 1) + k * 16'h0F11), 8'(8'h3C + 17 * i + k),
                              l[0], 8'(8'hA5 ^ (i * 8'h1D + k)), 1'b0, 1'b0);

        // R9: stray request held through every kind of cycle
        for (int k = 0; k < 6; k++)
            run_cycle(k, 16'hC0DE + 16'(k), 8'h77, 1'b1, 8'h5A + 8'(k), 1'b1, 1'b0);

        // R8: back-to-back cycles requested in the done clock
        run_cycle(0, 16'h2001, 8'h00, 1'b0, 8'h81, 1'b0, 1'b0);
        run_cycle(2, 16'h2002, 8'hE7, 1'b0, 8'h00, 1'b0, 1'b1);
        run_cycle(3, 16'h00F3, 8'h00, 1'b0, 8'h42, 1'b0, 1'b1);
        run_cycle(5, 16'h0000, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1);
        run_cycle(1, 16'hFFFF, 8'h00, 1'b0, 8'h19, 1'b0, 1'b1);

        // R9: kind codes 6 and 7 start nothing
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'hBEEF;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R9", "invalid kind ale", ale, 0);
            chk("R9", "invalid kind rd_n", rd_n, 1);
            chk("R9", "invalid kind wr_n", wr_n, 1);
            @(negedge clk);
            chk("R9", "invalid kind done", done, 0);
            chk("R9", "invalid kind status", {st1, st0}, 0);
        end
        run_cycle(1, 16'h4321, 8'h00, 1'b0, 8'h6E, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule